// File: doc/BRIEF.md
# Reset Sequencer with Oscillator Watchdog

This block is the reset controller of a low-power microcontroller whose system clock runs at about 32 kHz. It merges four causes of reset: power-on, return from sleep, a stalled system oscillator, and an external reset pin. It drives two outputs. The system reset re-initialises the chip. The CPU reset keeps the processor idle while the oscillator settles. The CPU reset lasts for a fixed number of system clock cycles after every system reset and after every wake-up.

The watchdog runs from a second, free-running reference clock. A slow toggle derived from the system clock crosses into the reference domain. If that toggle shows no edge for a window of reference cycles, the oscillator counts as stopped. The watchdog works only outside sleep and only while no stabilisation delay is counting. Software can switch it off with a disable bit, and every system reset switches it back on. The reset pin is filtered by a counter while the clock runs. In sleep the clock is off, so the pin acts on the system reset directly.

The system reset is held in a register in the system clock domain. The two sources that must act while that clock is dead (a stalled oscillator, and the pin during sleep) are ORed onto the output without passing through that register.

Top module: `rstseq_top`

## Requirements
- R1: While `por_i` is high, both `sys_rst_o` and `cpu_rst_o` read 1 from the first system clock edge on.
- R2: When the system reset ends, counted from the first edge that samples it low, `cpu_rst_o` stays 1 for DELAY_CYC edges. It first reads 0 after edge DELAY_CYC+1. This holds after a power-on release and after any other system reset.
- R3: When `sleep_i` falls, `cpu_rst_o` reads 1 after the third system clock edge. It first reads 0 after edge DELAY_CYC+3.
- R4: Outside sleep, if `rst_pin_i` is held high for N consecutive sampled cycles, a system reset results exactly when N >= DEB_CYC. For a long press, `sys_rst_o` first reads 1 after edge DEB_CYC+3 counted from the press.
- R5: A low sample on the pin restarts the filter count. Two presses of DEB_CYC-1 cycles each, separated by one low cycle, produce no system reset.
- R6: With `sleep_i` high and the system clock stopped, `sys_rst_o` follows `rst_pin_i` at once, with no clock edge needed.
- R7: Outside sleep, with the watchdog enabled and no delay running, a stopped system clock drives `sys_rst_o` to 1 within WD_WIN+4 reference cycles. When the clock restarts, the system reset ends and the delay of R2 follows.
- R8: A clock stop while the CPU reset delay is counting produces no system reset, and the delay resumes where it stopped.
- R9: Writing 1 to the disable bit (`wd_off_we_i`=1 with `wd_off_d_i`=1) stops the watchdog, so a clock stop produces no system reset.
- R10: Every system reset clears the disable bit, so after it a clock stop again produces a system reset.
- R11: A clock stop during sleep produces no system reset, neither while stopped nor after the wake-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock; may stop |
| ref_clk | input | 1 | Free-running reference clock for the watchdog |
| por_i | input | 1 | Power-on reset, active high, synchronous |
| sleep_i | input | 1 | 1 = sleep mode (oscillator off) |
| rst_pin_i | input | 1 | External reset pin, active high |
| wd_off_we_i | input | 1 | Write strobe for the watchdog disable bit |
| wd_off_d_i | input | 1 | Value written to the disable bit (1 = watchdog off) |
| sys_rst_o | output | 1 | System reset, active high |
| cpu_rst_o | output | 1 | CPU reset, active high |

## Verification
Every result has a fixed latency in system clock edges, counted from the first edge after the input changes:
- Power-on release: `sys_rst_o` drops after edge 1 and `cpu_rst_o` after edge DELAY_CYC+1.
- Long pin press: the reset rises after edge DEB_CYC+3.
- Wake-up: `cpu_rst_o` drops after edge DELAY_CYC+3.

The bench drives inputs and samples outputs 1 ns after a rising edge, and counts edges with a single tick task, so every check lands on the edge given above. The clock-domain handshake after a clock restart has variable latency, so the bench polls for the fall of `sys_rst_o` within a bound. It then counts the delay from that edge. Checks made while the clock is stopped are sampled after a wait of several watchdog windows.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    // CPU hold state of the stabilisation delay
    typedef enum logic {
        HOLD_OFF = 1'b0,
        HOLD_ON  = 1'b1
    } hold_e;

    // Control bits carried from the system domain into the reference domain
    typedef struct packed {
        logic sleep;   // sleep mode requested
        logic mask;    // stabilisation delay running
        logic wd_off;  // watchdog disabled by software
    } wd_ctl_t;

    localparam int WD_CTL_W = $bits(wd_ctl_t);

    // Counter width able to hold values 0 .. n-1
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st <= {st[STAGES-2:0], d};
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/rstseq_debounce.sv
module rstseq_debounce
    import rstseq_pkg::*;
#(
    parameter int DEB = 512
) (
    input  logic clk,
    input  logic por_i,
    input  logic pin_i,
    input  logic sleep_i,
    output logic trip_o
);
    localparam int            CW   = cnt_w(DEB);
    localparam logic [CW-1:0] LAST = CW'(DEB - 1);

    logic [CW-1:0] cnt;
    logic          trip_q;

    always_ff @(posedge clk) begin
        if (por_i) begin
            cnt    <= '0;
            trip_q <= 1'b0;
        end else begin
            trip_q <= pin_i & ~sleep_i & (cnt == LAST);
            if (!pin_i || sleep_i) begin
                cnt <= '0;
            end else if (cnt != LAST) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign trip_o = trip_q;

    AST_TRIP_NEEDS_PRESS: assert property (@(posedge clk) disable iff (por_i)
        $rose(trip_q) |-> $past(pin_i) && ($past(cnt) == LAST)); // R4
    AST_LOW_RESTARTS: assert property (@(posedge clk) disable iff (por_i)
        !pin_i |=> (cnt == '0) && !trip_q); // R5
endmodule

// File: rtl/rstseq_delay.sv
module rstseq_delay
    import rstseq_pkg::*;
#(
    parameter int DELAY = 32768
) (
    input  logic clk,
    input  logic por_i,
    input  logic sys_rst_i,
    input  logic wake_i,
    output logic hold_o
);
    localparam int            CW   = cnt_w(DELAY);
    localparam logic [CW-1:0] TERM = CW'(DELAY - 1);

    hold_e         st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (por_i || sys_rst_i || wake_i) begin
            st  <= HOLD_ON;
            cnt <= '0;
        end else if (st == HOLD_ON) begin
            if (cnt == TERM) begin
                st <= HOLD_OFF;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign hold_o = (st == HOLD_ON);

    AST_RELEASE_AT_TERM: assert property (@(posedge clk) disable iff (por_i)
        $fell(hold_o) |-> ($past(cnt) == TERM)); // R2
    AST_RESET_HOLDS_CPU: assert property (@(posedge clk) disable iff (por_i)
        sys_rst_i |=> hold_o); // R1
endmodule

// File: rtl/rstseq_oscmon.sv
module rstseq_oscmon
    import rstseq_pkg::*;
#(
    parameter int WIN      = 8,
    parameter int TOG_LOG2 = 2
) (
    input  logic    sys_clk,
    input  logic    ref_clk,
    input  logic    por_i,
    input  wd_ctl_t ctl_i,
    output logic    stop_o
);
    localparam int            CW   = cnt_w(WIN);
    localparam logic [CW-1:0] LAST = CW'(WIN - 1);

    // system domain: slow heartbeat toggle
    logic [TOG_LOG2:0] div;
    always_ff @(posedge sys_clk) begin
        if (por_i) div <= '0;
        else       div <= div + 1'b1;
    end

    // reference domain: bring heartbeat and controls across
    logic [WD_CTL_W:0] rq;
    rstseq_sync #(.W(WD_CTL_W + 1), .STAGES(2)) u_sync (
        .clk (ref_clk),
        .rst (por_i),
        .d   ({div[TOG_LOG2], ctl_i}),
        .q   (rq)
    );

    wd_ctl_t       ctl_s;
    logic          tog_s, tog_d, beat, en;
    logic [CW-1:0] cnt;
    logic          stop_q;

    assign ctl_s = rq[WD_CTL_W-1:0];
    assign tog_s = rq[WD_CTL_W];
    assign beat  = tog_s ^ tog_d;
    assign en    = ~ctl_s.sleep & ~ctl_s.mask & ~ctl_s.wd_off;

    always_ff @(posedge ref_clk) begin
        if (por_i) begin
            tog_d  <= 1'b0;
            cnt    <= '0;
            stop_q <= 1'b0;
        end else begin
            tog_d <= tog_s;
            if (ctl_s.mask) begin
                stop_q <= 1'b0;
            end else if (en && !beat && cnt == LAST) begin
                stop_q <= 1'b1;
            end
            if (!en || beat) begin
                cnt <= '0;
            end else if (cnt != LAST) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign stop_o = stop_q;

    AST_STOP_MASKED: assert property (@(posedge ref_clk) disable iff (por_i)
        ctl_s.mask |=> !stop_q); // R8
    AST_STOP_GATED: assert property (@(posedge ref_clk) disable iff (por_i)
        $rose(stop_q) |-> $past(!ctl_s.wd_off && !ctl_s.sleep)); // R9
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int DELAY_CYC = 32768,
    parameter int DEB_CYC   = 512,
    parameter int WD_WIN    = 8,
    parameter int TOG_LOG2  = 2
) (
    input  logic sys_clk,
    input  logic ref_clk,
    input  logic por_i,
    input  logic sleep_i,
    input  logic rst_pin_i,
    input  logic wd_off_we_i,
    input  logic wd_off_d_i,
    output logic sys_rst_o,
    output logic cpu_rst_o
);
    logic    stop_raw, stop_s, pin_s, sleep_s, sleep_d, wake;
    logic    trip, hold, sys_rst_q, wd_off_q;
    logic [2:0] sq;
    wd_ctl_t ctl;

    // asynchronous inputs into the system domain
    rstseq_sync #(.W(3), .STAGES(2)) u_sync (
        .clk (sys_clk),
        .rst (por_i),
        .d   ({stop_raw, rst_pin_i, sleep_i}),
        .q   (sq)
    );
    assign {stop_s, pin_s, sleep_s} = sq;
    assign wake = sleep_d & ~sleep_s;

    rstseq_debounce #(.DEB(DEB_CYC)) u_deb (
        .clk     (sys_clk),
        .por_i   (por_i),
        .pin_i   (pin_s),
        .sleep_i (sleep_s),
        .trip_o  (trip)
    );

    always_ff @(posedge sys_clk) begin
        if (por_i) begin
            sys_rst_q <= 1'b1;
            wd_off_q  <= 1'b0;
            sleep_d   <= 1'b0;
        end else begin
            sys_rst_q <= trip | stop_s;
            sleep_d   <= sleep_s;
            if (sys_rst_q)        wd_off_q <= 1'b0;
            else if (wd_off_we_i) wd_off_q <= wd_off_d_i;
        end
    end

    rstseq_delay #(.DELAY(DELAY_CYC)) u_dly (
        .clk       (sys_clk),
        .por_i     (por_i),
        .sys_rst_i (sys_rst_q),
        .wake_i    (wake),
        .hold_o    (hold)
    );

    assign ctl.sleep  = sleep_i;
    assign ctl.mask   = hold;
    assign ctl.wd_off = wd_off_q;

    rstseq_oscmon #(.WIN(WD_WIN), .TOG_LOG2(TOG_LOG2)) u_mon (
        .sys_clk (sys_clk),
        .ref_clk (ref_clk),
        .por_i   (por_i),
        .ctl_i   (ctl),
        .stop_o  (stop_raw)
    );

    // paths that must act while the system clock is dead bypass the register
    assign sys_rst_o = sys_rst_q | (sleep_i & rst_pin_i) | stop_raw;
    assign cpu_rst_o = hold | sys_rst_o;

    AST_OFF_CLEARED: assert property (@(posedge sys_clk) disable iff (por_i)
        $fell(sys_rst_q) |-> !wd_off_q); // R10
    AST_WAKE_HOLDS: assert property (@(posedge sys_clk) disable iff (por_i)
        wake |=> cpu_rst_o); // R3
endmodule

// File: tb/sim_rstseq_top.sv
module sim_rstseq_top;
    localparam int D  = 16;
    localparam int B  = 6;
    localparam int WW = 8;
    localparam int TL = 2;

    logic sys_clk = 1'b0;
    logic ref_clk = 1'b0;
    logic clk_run = 1'b1;
    logic por = 1'b1, sleep = 1'b0, pin = 1'b0, we = 1'b0, wd = 1'b0;
    logic sys_rst, cpu_rst;
    logic seen = 1'b0;
    logic done = 1'b0;
    int   nchk = 0;
    int   nerr = 0;

    rstseq_top #(.DELAY_CYC(D), .DEB_CYC(B), .WD_WIN(WW), .TOG_LOG2(TL)) u0 (
        .sys_clk     (sys_clk),
        .ref_clk     (ref_clk),
        .por_i       (por),
        .sleep_i     (sleep),
        .rst_pin_i   (pin),
        .wd_off_we_i (we),
        .wd_off_d_i  (wd),
        .sys_rst_o   (sys_rst),
        .cpu_rst_o   (cpu_rst)
    );

    always #7 ref_clk = ~ref_clk;
    always begin
        #4;
        if (clk_run) sys_clk = ~sys_clk;
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge sys_clk);
            #1;
            seen = seen | sys_rst;
        end
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wait_fall(input string req);
        int k = 0;
        while (sys_rst && k < 60) begin
            tick(1);
            k++;
        end
        chk(req, sys_rst, 1'b0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
        end
    end

    initial begin
        // R1: reset state during power-on
        tick(6);
        chk("R1 sys_rst", sys_rst, 1'b1);
        chk("R1 cpu_rst", cpu_rst, 1'b1);

        // R2: delay after power-on release
        por = 1'b0;
        tick(1);
        chk("R2 sys_rst released", sys_rst, 1'b0);
        chk("R2 cpu_rst held", cpu_rst, 1'b1);
        tick(D - 1);
        chk("R2 cpu_rst last held edge", cpu_rst, 1'b1);
        tick(1);
        chk("R2 cpu_rst released", cpu_rst, 1'b0);

        // R8: clock stop during the delay is ignored, delay resumes
        por = 1'b1;
        tick(6);
        por = 1'b0;
        tick(3);
        clk_run = 1'b0;
        #400;
        chk("R8 no reset while stopped", sys_rst, 1'b0);
        clk_run = 1'b1;
        tick(D - 3);
        chk("R8 cpu_rst held", cpu_rst, 1'b1);
        tick(1);
        chk("R8 cpu_rst released", cpu_rst, 1'b0);
        seen = 1'b0;
        tick(30);
        chk("R8 no late reset", seen, 1'b0);

        // R4: sweep of press lengths
        for (int n = 1; n <= B + 2; n++) begin
            seen = 1'b0;
            pin = 1'b1;
            tick(n);
            pin = 1'b0;
            tick(6);
            chk("R4 press sweep", seen, (n >= B) ? 1'b1 : 1'b0);
            if (n >= B) begin
                wait_fall("R4 sweep end");
                tick(D + 4);
            end
        end

        // R4: exact edge of a long press, then R2 after it
        pin = 1'b1;
        tick(B + 2);
        chk("R4 not yet", sys_rst, 1'b0);
        tick(1);
        chk("R4 reset edge", sys_rst, 1'b1);
        pin = 1'b0;
        wait_fall("R4 release");
        tick(D - 1);
        chk("R2 after pin reset held", cpu_rst, 1'b1);
        tick(1);
        chk("R2 after pin reset released", cpu_rst, 1'b0);

        // R5: a low sample restarts the count
        seen = 1'b0;
        pin = 1'b1;
        tick(B - 1);
        pin = 1'b0;
        tick(1);
        pin = 1'b1;
        tick(B - 1);
        pin = 1'b0;
        tick(6);
        chk("R5 split press", seen, 1'b0);

        // R7: stopped oscillator
        tick(10);
        clk_run = 1'b0;
        #400;
        chk("R7 sys_rst while stopped", sys_rst, 1'b1);
        chk("R7 cpu_rst while stopped", cpu_rst, 1'b1);
        clk_run = 1'b1;
        wait_fall("R7 release");
        tick(D - 1);
        chk("R7 cpu held", cpu_rst, 1'b1);
        tick(1);
        chk("R7 cpu released", cpu_rst, 1'b0);

        // R9: disable bit set
        tick(5);
        we = 1'b1;
        wd = 1'b1;
        tick(1);
        we = 1'b0;
        wd = 1'b0;
        tick(4);
        clk_run = 1'b0;
        #400;
        chk("R9 no reset while stopped", sys_rst, 1'b0);
        clk_run = 1'b1;
        seen = 1'b0;
        tick(20);
        chk("R9 no reset after restart", seen, 1'b0);

        // R10: a system reset clears the disable bit
        pin = 1'b1;
        tick(B + 3);
        pin = 1'b0;
        wait_fall("R10 pin reset end");
        tick(D + 10);
        clk_run = 1'b0;
        #400;
        chk("R10 watchdog re-armed", sys_rst, 1'b1);
        clk_run = 1'b1;
        wait_fall("R10 release");
        tick(D + 4);
        chk("R10 cpu released", cpu_rst, 1'b0);

        // R11, R6, R3: sleep, pin bypass, wake
        tick(5);
        sleep = 1'b1;
        tick(6);
        clk_run = 1'b0;
        #400;
        chk("R11 no reset in sleep", sys_rst, 1'b0);
        pin = 1'b1;
        #2;
        chk("R6 pin bypass sys", sys_rst, 1'b1);
        chk("R6 pin bypass cpu", cpu_rst, 1'b1);
        pin = 1'b0;
        #2;
        chk("R6 pin bypass off", sys_rst, 1'b0);
        #100;
        sleep = 1'b0;
        clk_run = 1'b1;
        seen = 1'b0;
        tick(3);
        chk("R3 wake hold", cpu_rst, 1'b1);
        tick(D - 1);
        chk("R3 wake last held edge", cpu_rst, 1'b1);
        tick(1);
        chk("R3 wake released", cpu_rst, 1'b0);
        tick(10);
        chk("R11 no reset after wake", seen, 1'b0);

        done = 1'b1;
        summary();
    end
endmodule